// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a single pixel clock into the full set of display raster timing. A horizontal counter steps once per pixel clock. A vertical counter steps once per completed line. Each axis has its own six timing points: the active extent, where the sync pulse starts and stops, where blanking starts and stops, and the period length. Each axis also has a sync polarity bit. All of these values count pixel-clock periods (horizontal) or lines (vertical).

From the two counters the block drives a pixel request strobe together with the current column and row, so that an upstream pixel source can supply data. It also drives the horizontal and vertical sync lines and a colour output. The colour output carries the pixel supplied on the request cycle inside the active area and a programmable border colour in the margins. It is clamped to black over the retrace and blanking regions. A margin can therefore sit between the picture and the black retrace band. Software writes new timing values at any time, but the counters only use them from the start of the next frame, so a frame never mixes two sets of timing.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal counter runs 0 to total-1 and then returns to 0. `pixX` equals the horizontal count, and `pixEn` is high exactly when the horizontal count is below the horizontal active width and the vertical count is below the vertical active width.
- R2: The vertical counter (`pixY`) steps by one on the clock after the horizontal count reaches total-1. It returns to 0 after line total-1.
- R3: `hSync` is registered. One clock after the horizontal count c satisfies sync-start <= c < sync-end, it is at its active level. Otherwise it is at its idle level.
- R4: `vSync` behaves the same way, using the vertical count and the vertical sync start and end.
- R5: When `pixEn` is high (and no blank or sync region applies), `rgbOut` on the next clock equals the `pixIn` value present on the `pixEn` cycle.
- R6: `rgbOut` is 0 one clock after any cycle in which either axis is in its sync region or in its blank region (blank-start <= c < blank-end).
- R7: In the remaining cycles (outside the active area, outside blank and sync), `rgbOut` on the next clock equals `borderColor`.
- R8: A write with `cfgWrEn` stores `cfgData` into a pending copy. The axis is chosen by `cfgAxisV` (0 horizontal, 1 vertical). The value is chosen by `cfgField`: 0 active width, 1 sync start, 2 sync end, 3 blank start, 4 blank end, 5 total, 6 polarity. Pending values replace the live ones only on the clock where both counters wrap to 0.
- R9: Field 6 stores `cfgData[0]`. With the bit at 0 the sync line is active-high; with the bit at 1 it is active-low.
- R10: While `rstN` is low, both counters are 0, `hSync`, `vSync` and `rgbOut` are 0, and the live and pending timing take the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Timing register write strobe |
| cfgAxisV | input | 1 | Write target axis: 0 horizontal, 1 vertical |
| cfgField | input | 3 | Timing value selector (see R8) |
| cfgData | input | CNT_W | Value written |
| borderColor | input | PIX_W | Margin colour |
| pixIn | input | PIX_W | Pixel data, sampled while `pixEn` is high |
| pixEn | output | 1 | Pixel request, inside the active area |
| pixX | output | CNT_W | Current column (horizontal count) |
| pixY | output | CNT_W | Current row (vertical count) |
| hSync | output | 1 | Horizontal sync, registered |
| vSync | output | 1 | Vertical sync, registered |
| rgbOut | output | PIX_W | Colour output, registered |

## Verification
The assertions take for granted that the programmed timing is well ordered on each axis: active width <= blank start <= sync start < sync end <= blank end <= total, with total at least 2. Under that ordering, blank and sync regions never overlap the active area, and the active area forms one unbroken run per line. The stimulus only writes complete modes that keep this ordering. It places those writes in the middle of a frame, so that the pending-versus-live behaviour is visible. It also switches the polarity and the border colour while the frame is running.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // selector codes for timing values; index order is also the storage order
  typedef enum logic [2:0] {
    FLD_ACT      = 3'd0,
    FLD_SYNC_ON  = 3'd1,
    FLD_SYNC_OFF = 3'd2,
    FLD_BLK_ON   = 3'd3,
    FLD_BLK_OFF  = 3'd4,
    FLD_TOTAL    = 3'd5,
    FLD_POL      = 3'd6
  } cfgField_e;

  localparam int NUM_PTS = 6;

  // strobes passed from control to datapath
  typedef struct packed {
    logic hAct;
    logic vAct;
    logic hSyncAct;
    logic vSyncAct;
    logic hBlank;
    logic vBlank;
    logic hPolLow;
    logic vPolLow;
  } rtgStrobe_t;

endpackage

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int CW      = 12,
  parameter int D_ACT   = 640,
  parameter int D_SS    = 664,
  parameter int D_SE    = 760,
  parameter int D_BS    = 648,
  parameter int D_BE    = 792,
  parameter int D_TOT   = 800
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrField,
  input  logic [CW-1:0] wrData,
  input  logic          advance,
  input  logic          commit,
  output logic [CW-1:0] cnt,
  output logic          atLast,
  output logic          inAct,
  output logic          inSync,
  output logic          inBlank,
  output logic          polLow
);

  localparam logic [CW-1:0] DEF_PTS [NUM_PTS] = '{
    CW'(D_ACT), CW'(D_SS), CW'(D_SE), CW'(D_BS), CW'(D_BE), CW'(D_TOT)
  };

  logic [CW-1:0] pendPts [NUM_PTS];
  logic [CW-1:0] livePts [NUM_PTS];
  logic          pendPol;

  // pending and live timing values
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PTS; i++) begin
        pendPts[i] <= DEF_PTS[i];
        livePts[i] <= DEF_PTS[i];
      end
      pendPol <= 1'b0;
      polLow  <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_PTS; i++) begin
        if (commit) livePts[i] <= pendPts[i];
        if (wrEn && wrField == 3'(i)) pendPts[i] <= wrData;
      end
      if (commit) polLow <= pendPol;
      if (wrEn && wrField == FLD_POL) pendPol <= wrData[0];
    end
  end

  assign atLast = (cnt == livePts[FLD_TOTAL] - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN)        cnt <= '0;
    else if (advance) cnt <= atLast ? '0 : cnt + 1'b1;
  end

  assign inAct   = cnt < livePts[FLD_ACT];
  assign inSync  = (cnt >= livePts[FLD_SYNC_ON]) && (cnt < livePts[FLD_SYNC_OFF]);
  assign inBlank = (cnt >= livePts[FLD_BLK_ON])  && (cnt < livePts[FLD_BLK_OFF]);

endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int CW    = 12,
  parameter int H_ACT = 640, parameter int H_SS = 664, parameter int H_SE = 760,
  parameter int H_BS  = 648, parameter int H_BE = 792, parameter int H_TOT = 800,
  parameter int V_ACT = 480, parameter int V_SS = 490, parameter int V_SE = 492,
  parameter int V_BS  = 484, parameter int V_BE = 520, parameter int V_TOT = 525
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic          cfgAxisV,
  input  logic [2:0]    cfgField,
  input  logic [CW-1:0] cfgData,
  output logic [CW-1:0] hCnt,
  output logic [CW-1:0] vCnt,
  output rtgStrobe_t    strobe
);

  logic hLast, vLast, frameWrap;
  logic hAct, hSyncR, hBlk, hPol;
  logic vAct, vSyncR, vBlk, vPol;

  assign frameWrap = hLast && vLast;

  rtg_axis #(
    .CW(CW), .D_ACT(H_ACT), .D_SS(H_SS), .D_SE(H_SE),
    .D_BS(H_BS), .D_BE(H_BE), .D_TOT(H_TOT)
  ) uHAxis (
    .clk(clk), .rstN(rstN),
    .wrEn(cfgWrEn && !cfgAxisV), .wrField(cfgField), .wrData(cfgData),
    .advance(1'b1), .commit(frameWrap),
    .cnt(hCnt), .atLast(hLast), .inAct(hAct), .inSync(hSyncR),
    .inBlank(hBlk), .polLow(hPol)
  );

  rtg_axis #(
    .CW(CW), .D_ACT(V_ACT), .D_SS(V_SS), .D_SE(V_SE),
    .D_BS(V_BS), .D_BE(V_BE), .D_TOT(V_TOT)
  ) uVAxis (
    .clk(clk), .rstN(rstN),
    .wrEn(cfgWrEn && cfgAxisV), .wrField(cfgField), .wrData(cfgData),
    .advance(hLast), .commit(frameWrap),
    .cnt(vCnt), .atLast(vLast), .inAct(vAct), .inSync(vSyncR),
    .inBlank(vBlk), .polLow(vPol)
  );

  always_comb begin
    strobe.hAct     = hAct;
    strobe.vAct     = vAct;
    strobe.hSyncAct = hSyncR;
    strobe.vSyncAct = vSyncR;
    strobe.hBlank   = hBlk;
    strobe.vBlank   = vBlk;
    strobe.hPolLow  = hPol;
    strobe.vPolLow  = vPol;
  end

endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  rtgStrobe_t    strobe,
  input  logic [PW-1:0] pixIn,
  input  logic [PW-1:0] borderColor,
  output logic          hSync,
  output logic          vSync,
  output logic [PW-1:0] rgbOut
);

  localparam logic [PW-1:0] BLACK = '0;

  logic          clampBlack;
  logic          inPicture;
  logic [PW-1:0] rgbNext;

  assign clampBlack = strobe.hSyncAct | strobe.vSyncAct | strobe.hBlank | strobe.vBlank;
  assign inPicture  = strobe.hAct & strobe.vAct;

  always_comb begin
    if (clampBlack)     rgbNext = BLACK;
    else if (inPicture) rgbNext = pixIn;
    else                rgbNext = borderColor;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hSync  <= 1'b0;
      vSync  <= 1'b0;
      rgbOut <= BLACK;
    end else begin
      hSync  <= strobe.hSyncAct ^ strobe.hPolLow;
      vSync  <= strobe.vSyncAct ^ strobe.vPolLow;
      rgbOut <= rgbNext;
    end
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PIX_W = 24,
  parameter int H_ACT = 640, parameter int H_SS = 664, parameter int H_SE = 760,
  parameter int H_BS  = 648, parameter int H_BE = 792, parameter int H_TOT = 800,
  parameter int V_ACT = 480, parameter int V_SS = 490, parameter int V_SE = 492,
  parameter int V_BS  = 484, parameter int V_BE = 520, parameter int V_TOT = 525
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgAxisV,
  input  logic [2:0]       cfgField,
  input  logic [CNT_W-1:0] cfgData,
  input  logic [PIX_W-1:0] borderColor,
  input  logic [PIX_W-1:0] pixIn,
  output logic             pixEn,
  output logic [CNT_W-1:0] pixX,
  output logic [CNT_W-1:0] pixY,
  output logic             hSync,
  output logic             vSync,
  output logic [PIX_W-1:0] rgbOut
);

  rtgStrobe_t strobe;

  rtg_ctrl #(
    .CW(CNT_W),
    .H_ACT(H_ACT), .H_SS(H_SS), .H_SE(H_SE), .H_BS(H_BS), .H_BE(H_BE), .H_TOT(H_TOT),
    .V_ACT(V_ACT), .V_SS(V_SS), .V_SE(V_SE), .V_BS(V_BS), .V_BE(V_BE), .V_TOT(V_TOT)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAxisV(cfgAxisV), .cfgField(cfgField), .cfgData(cfgData),
    .hCnt(pixX), .vCnt(pixY), .strobe(strobe)
  );

  assign pixEn = strobe.hAct & strobe.vAct;

  rtg_datapath #(.PW(PIX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pixIn(pixIn), .borderColor(borderColor),
    .hSync(hSync), .vSync(vSync), .rgbOut(rgbOut)
  );

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          pixEn,
  input logic [CW-1:0] pixX,
  input logic [CW-1:0] pixY,
  input logic [PW-1:0] pixIn,
  input logic [PW-1:0] rgbOut,
  input rtgStrobe_t    st
);

  // armed once a full cycle out of reset has been seen
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_x_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    armed && pixEn && $past(pixEn) |-> pixX == CW'($past(pixX) + 1'b1));

  assert_x_origin_R1: assert property (@(posedge clk) disable iff (!rstN)
    armed && pixEn && !$past(pixEn) |-> pixX == '0);

  assert_y_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed && pixEn && $past(pixEn) |-> pixY == $past(pixY));

  assert_pixel_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(pixEn) |-> rgbOut == $past(pixIn));

  assert_retrace_black_R6: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(st.hSyncAct || st.vSyncAct || st.hBlank || st.vBlank) |-> rgbOut == '0);

endmodule

bind raster_timing_gen rtg_checker #(.CW(CNT_W), .PW(PIX_W)) uChk (
  .clk(clk), .rstN(rstN), .pixEn(pixEn), .pixX(pixX), .pixY(pixY),
  .pixIn(pixIn), .rgbOut(rgbOut), .st(strobe)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;

  localparam int CW = 12;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic          cfgAxisV = 1'b0;
  logic [2:0]    cfgField = '0;
  logic [CW-1:0] cfgData = '0;
  logic [PW-1:0] borderColor = 24'h123456;
  logic [PW-1:0] pixIn = '0;
  logic          pixEn;
  logic [CW-1:0] pixX, pixY;
  logic          hSync, vSync;
  logic [PW-1:0] rgbOut;

  always #2 clk = ~clk;

  raster_timing_gen #(
    .CNT_W(CW), .PIX_W(PW),
    .H_ACT(8), .H_SS(10), .H_SE(13), .H_BS(9), .H_BE(15), .H_TOT(16),
    .V_ACT(4), .V_SS(6),  .V_SE(7),  .V_BS(5), .V_BE(8),  .V_TOT(9)
  ) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAxisV(cfgAxisV),
    .cfgField(cfgField), .cfgData(cfgData), .borderColor(borderColor),
    .pixIn(pixIn), .pixEn(pixEn), .pixX(pixX), .pixY(pixY),
    .hSync(hSync), .vSync(vSync), .rgbOut(rgbOut)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  // model state: index 0..5 timing points, 6 polarity
  int dH[7] = '{8, 10, 13, 9, 15, 16, 0};
  int dV[7] = '{4, 6, 7, 5, 8, 9, 0};
  int aH[7], sH[7], aV[7], sV[7];
  int mh, mv;
  int eH, eV, eR;
  string eRTag, eHTag, eVTag;
  int wrQ[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic bit pending();
    for (int i = 0; i < 7; i++) if (aH[i] != sH[i] || aV[i] != sV[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void pushWr(input int axis, input int field, input int data);
    wrQ.push_back((axis << 16) | (field << 12) | data);
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      mh = 0; mv = 0;
      aH = dH; sH = dH; aV = dV; sV = dV;
      eH = 0; eV = 0; eR = 0;
      eRTag = "R10"; eHTag = "R10"; eVTag = "R10";
      cfgWrEn = 1'b0;
    end else if (!done) begin
      bit hs, vs, hb, vb, act, hl, vl, blk;
      string tg;
      cyc++;
      tg = pending() ? "R8" : "R1";
      // combinational outputs against current model state
      act = (mh < aH[0]) && (mv < aV[0]);
      check(pixEn === act, tg, pixEn, act);
      check(pixX == CW'(mh), tg, pixX, mh);
      check(pixY == CW'(mv), pending() ? "R8" : "R2", pixY, mv);
      // registered outputs against last cycle's prediction
      check(hSync === eH[0], eHTag, hSync, eH);
      check(vSync === eV[0], eVTag, vSync, eV);
      check(rgbOut == PW'(eR), eRTag, rgbOut, eR);

      // new stimulus
      pixIn = PW'($urandom);
      if (cyc % 50 == 0) borderColor = PW'($urandom) | 24'h1;
      if (wrQ.size() > 0) begin
        int w;
        w = wrQ.pop_front();
        cfgWrEn  = 1'b1;
        cfgAxisV = w[16];
        cfgField = w[14:12];
        cfgData  = w[11:0];
      end else begin
        cfgWrEn = 1'b0;
      end

      // prediction for the registered outputs
      hs = (mh >= aH[1]) && (mh < aH[2]);
      vs = (mv >= aV[1]) && (mv < aV[2]);
      hb = (mh >= aH[3]) && (mh < aH[4]);
      vb = (mv >= aV[3]) && (mv < aV[4]);
      blk = hs | vs | hb | vb;
      eH = int'(hs) ^ aH[6];
      eV = int'(vs) ^ aV[6];
      eHTag = (aH[6] != 0) ? "R9" : "R3";
      eVTag = (aV[6] != 0) ? "R9" : "R4";
      if (blk) begin eR = 0; eRTag = "R6"; end
      else if (act) begin eR = int'(pixIn); eRTag = "R5"; end
      else begin eR = int'(borderColor); eRTag = "R7"; end

      // advance the model across the coming edge
      hl = (mh == aH[5] - 1);
      vl = (mv == aV[5] - 1);
      if (hl && vl) begin aH = sH; aV = sV; end
      if (cfgWrEn) begin
        int val;
        val = (cfgField == 3'd6) ? int'(cfgData[0]) : int'(cfgData);
        if (cfgAxisV) sV[cfgField] = val;
        else          sH[cfgField] = val;
      end
      if (hl) begin
        mh = 0;
        mv = vl ? 0 : mv + 1;
      end else begin
        mh = mh + 1;
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // reset state, R10
    check(hSync === 1'b0, "R10", hSync, 0);
    check(vSync === 1'b0, "R10", vSync, 0);
    check(rgbOut == '0, "R10", rgbOut, 0);
    check(pixX == '0 && pixY == '0, "R10", {pixX, pixY}, 0);
    @(posedge clk); #1 rstN = 1'b1;

    // default mode for two frames and more
    repeat (300) @(posedge clk);
    // mid-frame: new horizontal mode and active-low vertical sync (R8, R9)
    pushWr(0, 0, 6); pushWr(0, 1, 8); pushWr(0, 2, 10);
    pushWr(0, 3, 7); pushWr(0, 4, 11); pushWr(0, 5, 12);
    pushWr(1, 6, 1);
    repeat (500) @(posedge clk);
    // mid-frame: new vertical mode and active-low horizontal sync
    pushWr(1, 0, 3); pushWr(1, 1, 4); pushWr(1, 2, 6);
    pushWr(1, 3, 4); pushWr(1, 4, 7); pushWr(1, 5, 8);
    pushWr(0, 6, 1);
    repeat (600) @(posedge clk);
    // back to active-high on both axes
    pushWr(0, 6, 0); pushWr(1, 6, 0);
    repeat (300) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule